// File: doc/BRIEF.md
# Sixteen-Line Transmit DMA Scheduler

The scheduler moves outgoing bytes from memory to up to sixteen serial line transmitters. Each line owns a banked pair of registers: an 18-bit current address and a 16-bit byte count. Software reaches one line's pair at a time. It chooses that line through a select field in the control word. The count is loaded as the negative of the number of bytes to send. Setting the line's bit in the active mask starts the transfer.

While a line is active and its transmitter reports that it can take a byte, the scheduler competes for the single memory port on that line's behalf. Competing lines are served in rotating order, one byte per grant. Each fetched byte is handed to the transmitters together with its line number. The line's address then steps up by one and its count steps toward zero. When the count reaches zero, the hardware clears the line's active bit and sets a transmit-done flag, which can raise an interrupt.

If memory does not answer within a fixed window, the line is retired. A missing-memory error flag is set and the transmit-done flag is raised. After a line stops, software reads the address register back to learn how far the transfer got.

Top module: `txdma_sched`

## Requirements
- R1: After reset the active mask is zero, the control word reads zero (done flag bit 15 and missing-memory bit 10 both clear), memReq is low and irq is low.
- R2: Control-word bits 3:0 select a line. Writes and reads of the address register (select 1) and the count register (select 2) reach only that line's bank, and other lines keep their values.
- R3: An address write stores the 16 data bits as the low address and control bits 5:4 (from the last control write) as address bits 17:16. A control read returns the selected line's current address bits 17:16 in bits 5:4. The address increments across all 18 bits.
- R4: A write to the active mask (select 3) sets each bit written as 1. Bits written as 0 are left unchanged, so software cannot clear an active bit.
- R5: A line loaded with count -N sends exactly N bytes from consecutive addresses, with the count incrementing once per byte. When the count reaches zero its active bit clears.
- R6: Completion sets the done flag, control bit 15. irq equals the done flag ANDed with the enable, control bit 13. A control write with bit 15 at 0 clears the flag, and with bit 15 at 1 leaves it unchanged.
- R7: Among eligible lines, grants rotate in ascending line order, starting from the line after the last one served. After reset the first line searched is line 0.
- R8: A line whose txReady bit is low is never fetched for, and its count stays unchanged.
- R9: Writing count 0xFFFF to an active line ends its transfer after at most one more byte.
- R10: After a line stops, its address register reads its start address plus the number of bytes sent, and its count reads zero.
- R11: If memAck does not arrive within 16 cycles of memReq rising, the fetch is dropped. No byte is delivered, control bit 10 is set, the line's active bit clears and the done flag is set. A control write with bit 8 at 1 clears bit 10.
- R12: memReq stays high with a stable memAddr until memAck or the timeout. txValid pulses in the memAck cycle, carrying memData on txData and the line on txLine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 address, 2 count, 3 active mask |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for regSel |
| irq | output | 1 | Transmit-done interrupt |
| txReady | input | NUM_LINES | Per-line transmitter can accept a byte |
| txValid | output | 1 | Byte delivered this cycle |
| txLine | output | log2(NUM_LINES) | Line the delivered byte belongs to |
| txData | output | 8 | Delivered byte |
| memReq | output | 1 | Memory byte read request |
| memAddr | output | 18 | Memory byte address |
| memAck | input | 1 | Memory read completes, memData valid |
| memData | input | 8 | Memory read data |

## Verification
The bench goes after the low-address wrap into the high address bits. A design that dropped the carry would fetch from the wrong bank, and the compared byte values would expose it. It runs three lines at once with unequal counts, so a design that restarted the rotation at line 0 or served one line to the end would deliver bytes in the wrong order. It holds a line's transmitter off and then aborts with a count of -1. It also starves a fetch until it times out. A design that kept fetching, sent an extra byte or left the line active would show up in the byte stream, the mask readback or the error bit. Done-flag writes with bit 15 set and active-mask writes of zero are checked to leave state alone.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  localparam int EXT_BITS = 2;
  localparam int ADDR_W   = 16 + EXT_BITS;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ADDR   = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_ACTIVE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // memory returned a byte for curLine
    logic timeout;   // fetch for curLine abandoned
  } dmaStrobes_t;
endpackage

// File: rtl/txdma_rr_arb.sv
module txdma_rr_arb #(
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 4
) (
  input  logic [NUM_LINES-1:0] reqMask,
  input  logic [LINE_W-1:0]    lastIdx,
  output logic                 anyGrant,
  output logic [LINE_W-1:0]    grantIdx
);
  // search starts one past the last served line and wraps
  always_comb begin
    int idx;
    anyGrant = 1'b0;
    grantIdx = lastIdx;
    idx = 0;
    for (int off = 1; off <= NUM_LINES; off++) begin
      idx = (int'(lastIdx) + off) % NUM_LINES;
      if (!anyGrant && reqMask[idx]) begin
        anyGrant = 1'b1;
        grantIdx = LINE_W'(idx);
      end
    end
  end
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int NUM_LINES      = 16,
  parameter int LINE_W         = 4,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] activeMask,
  input  logic [NUM_LINES-1:0] txReady,
  input  logic                 memAck,
  output logic                 memReq,
  output logic [LINE_W-1:0]    curLine,
  output dmaStrobes_t          strobes
);
  localparam int WAIT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e            state;
  logic [LINE_W-1:0] lastLine;
  logic [WAIT_W-1:0] waitCnt;
  logic              anyGrant;
  logic [LINE_W-1:0] grantIdx;
  logic              waitDone;

  txdma_rr_arb #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_arb (
    .reqMask (activeMask & txReady),
    .lastIdx (lastLine),
    .anyGrant(anyGrant),
    .grantIdx(grantIdx)
  );

  assign waitDone        = (waitCnt == WAIT_LAST);
  assign memReq          = (state == ST_FETCH);
  assign strobes.advance = memReq && memAck;
  assign strobes.timeout = memReq && !memAck && waitDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curLine  <= '0;
      lastLine <= LINE_W'(NUM_LINES - 1);
      waitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (anyGrant) begin
            curLine <= grantIdx;
            waitCnt <= '0;
            state   <= ST_FETCH;
          end
        end
        default: begin
          if (memAck || waitDone) begin
            lastLine <= curLine;
            state    <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/txdma_datapath.sv
module txdma_datapath
  import txdma_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [1:0]           regSel,
  input  logic [15:0]          regWdata,
  output logic [15:0]          regRdata,
  input  dmaStrobes_t          strobes,
  input  logic [LINE_W-1:0]    curLine,
  output logic [NUM_LINES-1:0] activeMask,
  output logic [ADDR_W-1:0]    lineAddr,
  output logic                 irq
);
  logic [ADDR_W-1:0]   addrBank [NUM_LINES];
  logic [15:0]         cntBank  [NUM_LINES];
  logic [3:0]          lineSel;
  logic [EXT_BITS-1:0] extSel;
  logic                tiFlag, tieFlag, nxmFlag;
  logic                wrCtrl, wrAddr, wrCount, wrActive;
  logic                lastByte;
  logic [NUM_LINES-1:0] doneMask;
  logic [LINE_W-1:0]   selIdx;
  logic [15:0]         activeWide;

  assign selIdx   = lineSel[LINE_W-1:0];
  assign wrCtrl   = regWe && (regSel == SEL_CTRL);
  assign wrAddr   = regWe && (regSel == SEL_ADDR);
  assign wrCount  = regWe && (regSel == SEL_COUNT);
  assign wrActive = regWe && (regSel == SEL_ACTIVE);
  assign lastByte = (cntBank[curLine] == 16'hFFFF);
  assign lineAddr = addrBank[curLine];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit         = strobes.advance && (curLine == LINE_W'(g));
    assign doneMask[g] = (curLine == LINE_W'(g)) &&
                         (strobes.timeout || (strobes.advance && lastByte));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrBank[g] <= '0;
        cntBank[g]  <= '0;
      end else begin
        if (wrAddr && selIdx == LINE_W'(g))
          addrBank[g] <= {extSel, regWdata};
        else if (hit)
          addrBank[g] <= addrBank[g] + 1'b1;
        if (wrCount && selIdx == LINE_W'(g))
          cntBank[g] <= regWdata;
        else if (hit)
          cntBank[g] <= cntBank[g] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= '0;
      lineSel    <= '0;
      extSel     <= '0;
      tiFlag     <= 1'b0;
      tieFlag    <= 1'b0;
      nxmFlag    <= 1'b0;
    end else begin
      // a software start wins over a same-cycle hardware retire
      activeMask <= (activeMask & ~doneMask) |
                    (wrActive ? regWdata[NUM_LINES-1:0] : '0);
      if (wrCtrl) begin
        lineSel <= regWdata[3:0];
        extSel  <= regWdata[5:4];
        tieFlag <= regWdata[13];
      end
      if (|doneMask)                    tiFlag <= 1'b1;
      else if (wrCtrl && !regWdata[15]) tiFlag <= 1'b0;
      if (strobes.timeout)              nxmFlag <= 1'b1;
      else if (wrCtrl && regWdata[8])   nxmFlag <= 1'b0;
    end
  end

  assign irq = tiFlag && tieFlag;

  always_comb begin
    activeWide = '0;
    activeWide[NUM_LINES-1:0] = activeMask;
    case (regSel)
      SEL_CTRL:  regRdata = {tiFlag, 1'b0, tieFlag, 2'b00, nxmFlag, 4'b0000,
                             addrBank[selIdx][ADDR_W-1:16], lineSel};
      SEL_ADDR:  regRdata = addrBank[selIdx][15:0];
      SEL_COUNT: regRdata = cntBank[selIdx];
      default:   regRdata = activeWide;
    endcase
  end
endmodule

// File: rtl/txdma_sched.sv
module txdma_sched
  import txdma_pkg::*;
#(
  parameter int NUM_LINES      = 16,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWe,
  input  logic [1:0]                   regSel,
  input  logic [15:0]                  regWdata,
  output logic [15:0]                  regRdata,
  output logic                         irq,
  input  logic [NUM_LINES-1:0]         txReady,
  output logic                         txValid,
  output logic [$clog2(NUM_LINES)-1:0] txLine,
  output logic [7:0]                   txData,
  output logic                         memReq,
  output logic [17:0]                  memAddr,
  input  logic                         memAck,
  input  logic [7:0]                   memData
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] activeMask;
  logic [LINE_W-1:0]    curLine;
  dmaStrobes_t          strobes;

  txdma_ctrl #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W),
               .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .activeMask(activeMask), .txReady(txReady),
    .memAck(memAck), .memReq(memReq), .curLine(curLine), .strobes(strobes)
  );

  txdma_datapath #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_datapath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .strobes(strobes),
    .curLine(curLine), .activeMask(activeMask), .lineAddr(memAddr),
    .irq(irq)
  );

  assign txValid = strobes.advance;
  assign txLine  = curLine;
  assign txData  = memData;
endmodule

// File: rtl/txdma_sched_chk.sv
module txdma_sched_chk #(
  parameter int NUM_LINES      = 16,
  parameter int TIMEOUT_CYCLES = 16
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         memReq,
  input logic                         memAck,
  input logic [17:0]                  memAddr,
  input logic                         txValid,
  input logic [$clog2(NUM_LINES)-1:0] txLine,
  input logic [NUM_LINES-1:0]         activeMask,
  input logic                         nxmFlag
);
  int reqCycles;

  always_ff @(posedge clk) begin
    if (!rstN) reqCycles <= 0;
    else if (memReq && !memAck) reqCycles <= reqCycles + 1;
    else reqCycles <= 0;
  end

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck && reqCycles < TIMEOUT_CYCLES - 1 |=> memReq && $stable(memAddr));

  assert_drop_after_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq);

  assert_valid_on_ack_R12: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> memReq && memAck);

  assert_req_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> reqCycles < TIMEOUT_CYCLES);

  assert_nxm_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nxmFlag) |-> $past(memReq && !memAck));

  assert_req_line_active_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> activeMask[txLine]);
endmodule

bind txdma_sched txdma_sched_chk #(
  .NUM_LINES(NUM_LINES), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck),
  .memAddr(memAddr), .txValid(txValid), .txLine(txLine),
  .activeMask(activeMask), .nxmFlag(u_datapath.nxmFlag)
);

// File: tb/test_txdma_sched.sv
module test_txdma_sched;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        irq;
  logic [15:0] txReady = '1;
  logic        txValid;
  logic [3:0]  txLine;
  logic [7:0]  txData;
  logic        memReq;
  logic [17:0] memAddr;
  logic        memAck = 1'b0;
  logic [7:0]  memData = '0;

  always #10 clk = ~clk;

  txdma_sched i_txdma_sched (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq),
    .txReady(txReady), .txValid(txValid), .txLine(txLine),
    .txData(txData), .memReq(memReq), .memAddr(memAddr),
    .memAck(memAck), .memData(memData)
  );

  typedef struct {
    int          line;
    logic [17:0] addr;
    string       tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    errors = 0;
  int    byteCount = 0;
  int    ackLatency = 0;
  bit    noAck = 1'b0;
  int    waitCnt = 0;
  bit    tieBit = 1'b0;

  function automatic logic [7:0] memByte(input logic [17:0] a);
    return a[7:0] ^ {a[15:10], a[17:16]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: acknowledges after ackLatency waiting cycles
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck <= 1'b0;
      waitCnt = 0;
    end else if (memReq && !noAck) begin
      if (waitCnt >= ackLatency) begin
        memAck  <= 1'b1;
        memData <= memByte(memAddr);
      end else begin
        waitCnt++;
      end
    end else if (!memReq) begin
      waitCnt = 0;
    end
  end

  // monitor: pop expected bytes and compare
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rstN && txValid) begin
        byteCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "unexpected byte on line", 32'(txLine), 32'hFFFF);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(txLine == 4'(it.line), it.tag, "byte line", 32'(txLine), 32'(it.line));
          check(txData == memByte(it.addr), it.tag, "byte data", 32'(txData),
                32'(memByte(it.addr)));
        end
      end
    end
  end

  task automatic regWrite(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    regWe    = 1'b1;
    regSel   = sel;
    regWdata = data;
    @(negedge clk);
    regWe    = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] data);
    @(negedge clk);
    regSel = sel;
    #5;
    data = regRdata;
  endtask

  function automatic logic [15:0] ctrlWord(input int line, input int ext,
                                           input bit keepTi, input bit clrNxm);
    return {keepTi, 1'b0, tieBit, 4'b0000, clrNxm, 2'b00, 2'(ext), 4'(line)};
  endfunction

  task automatic setupLine(input int line, input int ext, input logic [15:0] addr,
                           input logic [15:0] cnt);
    regWrite(2'd0, ctrlWord(line, ext, 1'b1, 1'b0));
    regWrite(2'd1, addr);
    regWrite(2'd2, cnt);
  endtask

  task automatic expectByte(input int line, input logic [17:0] addr, input string tag);
    item_t it;
    it.line = line;
    it.addr = addr;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic waitDrain();
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 5000) begin
      @(posedge clk);
      n++;
    end
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int seen;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd0, rd);
    check(rd == 16'h0000, "R1", "control after reset", 32'(rd), 32'h0);
    regRead(2'd3, rd);
    check(rd == 16'h0000, "R1", "active mask after reset", 32'(rd), 32'h0);
    check(memReq == 1'b0, "R1", "memReq after reset", 32'(memReq), 32'h0);
    check(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'h0);

    // R2 banking, R3 high address bits
    setupLine(4, 1, 16'h1234, 16'hFFF0);
    setupLine(6, 0, 16'hABCD, 16'hFFFE);
    regWrite(2'd0, ctrlWord(4, 0, 1'b1, 1'b0));
    regRead(2'd1, rd);
    check(rd == 16'h1234, "R2", "line 4 address kept", 32'(rd), 32'h1234);
    regRead(2'd2, rd);
    check(rd == 16'hFFF0, "R2", "line 4 count kept", 32'(rd), 32'hFFF0);
    regRead(2'd0, rd);
    check(rd[5:4] == 2'd1, "R3", "line 4 high address bits", 32'(rd[5:4]), 32'h1);
    regWrite(2'd0, ctrlWord(6, 0, 1'b1, 1'b0));
    regRead(2'd1, rd);
    check(rd == 16'hABCD, "R2", "line 6 address", 32'(rd), 32'hABCD);

    // R5 R7 R3 round-robin across three lines, with carry into the high bits
    tieBit = 1'b1;
    ackLatency = 1;
    setupLine(2, 0, 16'h0100, 16'hFFFE);
    setupLine(5, 2, 16'hFFFF, 16'hFFFD);
    setupLine(9, 1, 16'h0040, 16'hFFFF);
    expectByte(2, 18'h00100, "R7");
    expectByte(5, 18'h2FFFF, "R7");
    expectByte(9, 18'h10040, "R7");
    expectByte(2, 18'h00101, "R7");
    expectByte(5, 18'h30000, "R3");
    expectByte(5, 18'h30001, "R5");
    regWrite(2'd3, 16'h0224);
    waitDrain();
    regRead(2'd3, rd);
    check(rd == 16'h0000, "R5", "active mask after completion", 32'(rd), 32'h0);
    regRead(2'd0, rd);
    check(rd[15] == 1'b1, "R6", "done flag set", 32'(rd[15]), 32'h1);
    check(irq == 1'b1, "R6", "irq with enable", 32'(irq), 32'h1);
    regWrite(2'd0, ctrlWord(5, 0, 1'b1, 1'b0));
    regRead(2'd0, rd);
    check(rd[15] == 1'b1, "R6", "done flag kept by bit15=1 write", 32'(rd[15]), 32'h1);
    check(rd[5:4] == 2'd3, "R3", "high bits after carry", 32'(rd[5:4]), 32'h3);
    regRead(2'd1, rd);
    check(rd == 16'h0002, "R10", "stop address line 5", 32'(rd), 32'h0002);
    regRead(2'd2, rd);
    check(rd == 16'h0000, "R10", "final count line 5", 32'(rd), 32'h0);
    regWrite(2'd0, ctrlWord(5, 0, 1'b0, 1'b0));
    regRead(2'd0, rd);
    check(rd[15] == 1'b0, "R6", "done flag cleared", 32'(rd[15]), 32'h0);
    check(irq == 1'b0, "R6", "irq cleared", 32'(irq), 32'h0);

    // R8 gating, R4 set-only mask, R9 abort
    tieBit = 1'b0;
    ackLatency = 0;
    txReady[3] = 1'b0;
    setupLine(3, 0, 16'h0500, 16'hFFF6);
    seen = byteCount;
    regWrite(2'd3, 16'h0008);
    repeat (30) @(posedge clk);
    check(byteCount == seen, "R8", "bytes while not ready", 32'(byteCount), 32'(seen));
    regRead(2'd2, rd);
    check(rd == 16'hFFF6, "R8", "count while not ready", 32'(rd), 32'hFFF6);
    regWrite(2'd3, 16'h0000);
    regRead(2'd3, rd);
    check(rd == 16'h0008, "R4", "zero write leaves mask", 32'(rd), 32'h0008);
    regWrite(2'd2, 16'hFFFF);
    expectByte(3, 18'h00500, "R9");
    seen = byteCount;
    txReady[3] = 1'b1;
    waitDrain();
    repeat (10) @(posedge clk);
    check(byteCount == seen + 1, "R9", "bytes after abort", 32'(byteCount), 32'(seen + 1));
    regRead(2'd3, rd);
    check(rd == 16'h0000, "R9", "mask after abort", 32'(rd), 32'h0);
    regRead(2'd1, rd);
    check(rd == 16'h0501, "R10", "stop address line 3", 32'(rd), 32'h0501);
    regRead(2'd0, rd);
    check(rd[15] == 1'b1 && irq == 1'b0, "R6", "done flag with enable off",
          32'({rd[15], irq}), 32'h2);

    // R11 timeout
    regWrite(2'd0, ctrlWord(3, 0, 1'b0, 1'b0));
    noAck = 1'b1;
    setupLine(7, 0, 16'h0700, 16'hFFFC);
    seen = byteCount;
    regWrite(2'd3, 16'h0080);
    repeat (40) @(posedge clk);
    check(byteCount == seen, "R11", "no byte on timeout", 32'(byteCount), 32'(seen));
    regRead(2'd0, rd);
    check(rd[10] == 1'b1, "R11", "error bit set", 32'(rd[10]), 32'h1);
    check(rd[15] == 1'b1, "R11", "done flag on timeout", 32'(rd[15]), 32'h1);
    regRead(2'd3, rd);
    check(rd == 16'h0000, "R11", "line retired on timeout", 32'(rd), 32'h0);
    regWrite(2'd0, ctrlWord(7, 0, 1'b1, 1'b1));
    regRead(2'd0, rd);
    check(rd[10] == 1'b0, "R11", "error bit cleared", 32'(rd[10]), 32'h0);
    noAck = 1'b0;

    // R12 slow memory
    ackLatency = 4;
    setupLine(0, 0, 16'h0010, 16'hFFFE);
    expectByte(0, 18'h00010, "R12");
    expectByte(0, 18'h00011, "R12");
    regWrite(2'd3, 16'h0001);
    waitDrain();
    check(expQ.size() == 0, "R12", "all expected bytes delivered",
          32'(expQ.size()), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule